// File: doc/BRIEF.md
# Permissioned Device Control Register File

This block holds sixteen 16-bit control registers for one device that sits on a bus shared by several devices. Every access carries the ID of the requester and a 4-bit register index. The block sorts the requester into one of three classes: the device itself, the device that currently owns the bus, or an outsider. A read mask and a write mask for each class decide which registers that requester may see or change.

Register 0 returns the fixed device ID to anyone and cannot be written. Register 1 holds a bank index in its upper byte and the low byte of the device type in its lower byte. Register 2 holds the ID of the bus owner, register 3 holds interrupt code and status, and register 4 holds a handler address. Registers 5 to 15 are plain storage for type-specific use.

An accepted write from the bus owner produces a one-cycle update strobe that carries the index and data. A halt notice from the owner clears the ownership field. A separate load input replaces the bank byte.

Top module: `perm_ctrl_regs`

## Requirements
- R1: A read of index 0 returns DEV_ID for every requester class, and a write to index 0 is always dropped.
- R2: Register 1 reads as {bank byte, DEV_TYPE[7:0]}. The bank byte is 0 after reset. When bank_load is high, the bank byte takes bank_idx at the next edge and the type byte does not change.
- R3: The requester class is chosen in priority order. An ID equal to DEV_ID is self. Otherwise an ID equal to the current value of register 2 is the owner. Any other ID is external.
- R4: For an index n of 1 or more, a read is allowed only when bit n-1 of the class read mask is set. Otherwise the read returns 0. Both default read masks are 0x001F, so only registers 1 to 5 can be read.
- R5: rd_data is combinational and valid in the same cycle as a read request. It is 0 when no read is requested.
- R6: A self write uses mask 0x000C by default, so only registers 3 and 4 can be written. The new value can be read from the next cycle.
- R7: An owner write uses mask 0x0010 by default, so only register 5 can be written. Each accepted owner write sets upd_valid high for exactly the next cycle, with upd_idx and upd_data holding the index and data of that write.
- R8: Self writes, denied writes and external writes never raise upd_valid. An external write changes no register.
- R9: A halt notice whose ID equals register 2 clears register 2 to 0 at the next edge. A halt notice with any other ID has no effect.
- R10: After reset, registers 2 to 15 are 0 and upd_valid is low. Because register 2 is 0, a requester with ID 0 (other than self) is treated as the owner.
- R11: If an accepted write to register 2 and a matching halt notice arrive in the same cycle, the write wins.
- R12: The write masks are parameters. For example, a self write mask of 0x000E lets the device grant ownership by writing register 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_req_id | input | 16 | Requester ID |
| acc_idx | input | 4 | Register index |
| acc_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, same cycle |
| halt_valid | input | 1 | Halt notice |
| halt_id | input | 16 | ID of the halted device |
| bank_load | input | 1 | Load the bank byte |
| bank_idx | input | 8 | New bank byte |
| dev_id_o | output | 16 | Fixed device ID |
| dev_type_o | output | 8 | Stored device type byte |
| upd_valid | output | 1 | Owner-write update strobe |
| upd_idx | output | 4 | Index of the owner write |
| upd_data | output | 16 | Data of the owner write |

## Verification
Two instances run side by side. One uses the default masks. The other has a self write mask that also covers register 2, so ownership can move away from ID 0 and come back. Directed steps check index 0, bank loads, self writes to allowed and denied registers, writes from outsiders, the owner strobe, a halt that matches and one that does not, and a write to register 2 in the same cycle as a halt. Random steps then mix requesters chosen as self, current owner, ID 0 and arbitrary IDs over all indices. This separates mistakes in classification order from mistakes in mask bit selection.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  typedef enum logic [1:0] {
    CLS_SELF  = 2'd0,
    CLS_OWNER = 2'd1,
    CLS_EXT   = 2'd2
  } req_class_e;
endpackage

// File: rtl/pcr_rst_sync.sv
module pcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/pcr_access_check.sv
module pcr_access_check
  import pcr_pkg::*;
#(
  parameter int          DATA_W        = 16,
  parameter int          NREG          = 16,
  parameter int          IDX_W         = 4,
  parameter logic [15:0] DEV_ID        = 16'h00A5,
  parameter logic [NREG-1:0] PRIV_RD_MASK  = 16'h001F,
  parameter logic [NREG-1:0] EXT_RD_MASK   = 16'h001F,
  parameter logic [NREG-1:0] SELF_WR_MASK  = 16'h000C,
  parameter logic [NREG-1:0] OWNER_WR_MASK = 16'h0010
) (
  input  logic [DATA_W-1:0] req_id,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] owner_id,
  output req_class_e        cls,
  output logic              rd_ok,
  output logic              wr_ok
);
  logic [IDX_W-1:0] bit_sel;
  logic             idx_zero;

  always_comb begin
    if (req_id == DEV_ID[DATA_W-1:0])  cls = CLS_SELF;
    else if (req_id == owner_id)       cls = CLS_OWNER;
    else                               cls = CLS_EXT;
  end

  assign idx_zero = (idx == '0);
  assign bit_sel  = idx - 1'b1;

  always_comb begin
    if (idx_zero)             rd_ok = 1'b1;
    else if (cls == CLS_EXT)  rd_ok = EXT_RD_MASK[bit_sel];
    else                      rd_ok = PRIV_RD_MASK[bit_sel];
  end

  always_comb begin
    if (idx_zero)                 wr_ok = 1'b0;
    else if (cls == CLS_SELF)     wr_ok = SELF_WR_MASK[bit_sel];
    else if (cls == CLS_OWNER)    wr_ok = OWNER_WR_MASK[bit_sel];
    else                          wr_ok = 1'b0;
  end
endmodule

// File: rtl/pcr_regfile.sv
module pcr_regfile #(
  parameter int          DATA_W   = 16,
  parameter int          NREG     = 16,
  parameter int          IDX_W    = 4,
  parameter logic [15:0] DEV_ID   = 16'h00A5,
  parameter logic [15:0] DEV_TYPE = 16'h1234
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [IDX_W-1:0]            widx,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        bank_load,
  input  logic [DATA_W/2-1:0]         bank_idx,
  input  logic                        halt_valid,
  input  logic [DATA_W-1:0]           halt_id,
  output logic [NREG-1:0][DATA_W-1:0] regs_o
);
  localparam int HALF_W = DATA_W / 2;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    if (k == 0) begin : g_id
      assign regs_o[k] = DEV_ID[DATA_W-1:0];
    end else if (k == 1) begin : g_bank
      logic [HALF_W-1:0] bank_q, bank_d;
      logic              bank_en;
      always_comb begin
        bank_en = bank_load || (we && widx == IDX_W'(k));
        bank_d  = bank_load ? bank_idx : wdata[DATA_W-1:HALF_W];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bank_q <= '0;
        else if (bank_en) bank_q <= bank_d;
      end
      assign regs_o[k] = {bank_q, DEV_TYPE[HALF_W-1:0]};
    end else if (k == 2) begin : g_owner
      logic [DATA_W-1:0] own_q, own_d;
      logic              own_en, wr_hit, halt_hit;
      always_comb begin
        wr_hit   = we && (widx == IDX_W'(k));
        halt_hit = halt_valid && (halt_id == own_q);
        own_en   = wr_hit || halt_hit;
        own_d    = wr_hit ? wdata : '0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      own_q <= '0;
        else if (own_en) own_q <= own_d;
      end
      assign regs_o[k] = own_q;
    end else begin : g_plain
      logic [DATA_W-1:0] val_q;
      logic              val_en;
      assign val_en = we && (widx == IDX_W'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      val_q <= '0;
        else if (val_en) val_q <= wdata;
      end
      assign regs_o[k] = val_q;
    end
  end

  // R9: a matching halt, without a competing write, empties the owner field
  assert_halt_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_valid && halt_id == regs_o[2] && !(we && widx == IDX_W'(2)))
      |=> (regs_o[2] == '0));

  // R11: a write to register 2 beats a halt in the same cycle
  assert_write_beats_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx == IDX_W'(2)) |=> (regs_o[2] == $past(wdata)));

  // R2: a bank load lands in the upper byte
  assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_load |=> (regs_o[1][DATA_W-1:HALF_W] == $past(bank_idx)));

  // R8: with no write, halt or load, the file holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !bank_load && !halt_valid) |=> $stable(regs_o));
endmodule

// File: rtl/perm_ctrl_regs.sv
module perm_ctrl_regs
  import pcr_pkg::*;
#(
  parameter int          DATA_W        = 16,
  parameter int          NREG          = 16,
  parameter logic [15:0] DEV_ID        = 16'h00A5,
  parameter logic [15:0] DEV_TYPE      = 16'h1234,
  parameter logic [15:0] PRIV_RD_MASK  = 16'h001F,
  parameter logic [15:0] EXT_RD_MASK   = 16'h001F,
  parameter logic [15:0] SELF_WR_MASK  = 16'h000C,
  parameter logic [15:0] OWNER_WR_MASK = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [DATA_W-1:0] acc_req_id,
  input  logic [3:0]        acc_idx,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              halt_valid,
  input  logic [DATA_W-1:0] halt_id,
  input  logic              bank_load,
  input  logic [7:0]        bank_idx,
  output logic [DATA_W-1:0] dev_id_o,
  output logic [7:0]        dev_type_o,
  output logic              upd_valid,
  output logic [3:0]        upd_idx,
  output logic [DATA_W-1:0] upd_data
);
  localparam int IDX_W  = $clog2(NREG);
  localparam int HALF_W = DATA_W / 2;

  logic                        rst_s_n;
  logic [NREG-1:0][DATA_W-1:0] regs;
  req_class_e                  cls;
  logic                        rd_ok, wr_ok, wr_acc, upd_d;

  pcr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  pcr_access_check #(
    .DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W), .DEV_ID(DEV_ID),
    .PRIV_RD_MASK(PRIV_RD_MASK[NREG-1:0]), .EXT_RD_MASK(EXT_RD_MASK[NREG-1:0]),
    .SELF_WR_MASK(SELF_WR_MASK[NREG-1:0]), .OWNER_WR_MASK(OWNER_WR_MASK[NREG-1:0])
  ) u_chk (
    .req_id(acc_req_id), .idx(acc_idx), .owner_id(regs[2]),
    .cls(cls), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  assign wr_acc = acc_valid && acc_write && wr_ok;
  assign upd_d  = wr_acc && (cls == CLS_OWNER);

  pcr_regfile #(
    .DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W),
    .DEV_ID(DEV_ID), .DEV_TYPE(DEV_TYPE)
  ) u_rf (
    .clk(clk), .rst_n(rst_s_n), .we(wr_acc), .widx(acc_idx), .wdata(acc_wdata),
    .bank_load(bank_load), .bank_idx(bank_idx[HALF_W-1:0]),
    .halt_valid(halt_valid), .halt_id(halt_id), .regs_o(regs)
  );

  always_comb begin
    if (acc_valid && !acc_write && rd_ok) rd_data = regs[acc_idx];
    else                                  rd_data = '0;
  end

  assign dev_id_o   = regs[0];
  assign dev_type_o = regs[1][HALF_W-1:0];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) upd_valid <= 1'b0;
    else          upd_valid <= upd_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      upd_idx  <= '0;
      upd_data <= '0;
    end else if (upd_d) begin
      upd_idx  <= acc_idx;
      upd_data <= acc_wdata;
    end
  end

  // R1: index 0 always answers with the fixed ID
  assert_id_read_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc_valid && !acc_write && acc_idx == '0) |-> (rd_data == DEV_ID[DATA_W-1:0]));

  // R4: a denied read reads as zero
  assert_denied_read_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc_valid && !acc_write && !rd_ok) |-> (rd_data == '0));

  // R7: a strobe always follows an accepted owner write and carries its data
  assert_upd_source_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    upd_valid |-> ($past(acc_valid && acc_write && wr_ok && cls == CLS_OWNER)
                   && upd_data == $past(acc_wdata) && upd_idx == $past(acc_idx)));

  // R8: non-owner writes never strobe
  assert_no_upd_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc_valid && acc_write && cls != CLS_OWNER) |=> !upd_valid);

  // R3: the device's own ID always classes as self
  assert_self_first_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc_req_id == DEV_ID[DATA_W-1:0]) |-> (cls == CLS_SELF));
endmodule

// File: tb/tb_perm_ctrl_regs.sv
module tb_perm_ctrl_regs;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] SELF_ID    = 16'h00A5;
  localparam logic [15:0] TYPE_V     = 16'h1234;
  localparam logic [15:0] RD_M       = 16'h001F;
  localparam logic [15:0] OWN_WM     = 16'h0010;
  localparam logic [15:0] EXT_ID     = 16'h0300;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write, halt_valid, bank_load;
  logic [15:0] acc_req_id, acc_wdata, halt_id;
  logic [3:0]  acc_idx;
  logic [7:0]  bank_idx;

  logic [15:0] rd_a, rd_b, id_a, id_b, ud_a, ud_b;
  logic [7:0]  ty_a, ty_b;
  logic        uv_a, uv_b;
  logic [3:0]  ui_a, ui_b;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] mreg [2][16];
  logic [15:0] swm  [2];
  logic        pv   [2];
  logic [3:0]  pidx [2];
  logic [15:0] pdat [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  perm_ctrl_regs #(.DEV_ID(SELF_ID), .DEV_TYPE(TYPE_V)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_req_id(acc_req_id), .acc_idx(acc_idx), .acc_wdata(acc_wdata), .rd_data(rd_a),
    .halt_valid(halt_valid), .halt_id(halt_id), .bank_load(bank_load), .bank_idx(bank_idx),
    .dev_id_o(id_a), .dev_type_o(ty_a), .upd_valid(uv_a), .upd_idx(ui_a), .upd_data(ud_a)
  );

  // R12: second instance whose self write mask also covers register 2
  perm_ctrl_regs #(.DEV_ID(SELF_ID), .DEV_TYPE(TYPE_V), .SELF_WR_MASK(16'h000E)) dut_g (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_req_id(acc_req_id), .acc_idx(acc_idx), .acc_wdata(acc_wdata), .rd_data(rd_b),
    .halt_valid(halt_valid), .halt_id(halt_id), .bank_load(bank_load), .bank_idx(bank_idx),
    .dev_id_o(id_b), .dev_type_o(ty_b), .upd_valid(uv_b), .upd_idx(ui_b), .upd_data(ud_b)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int mcls(int c, logic [15:0] id);
    if (id == SELF_ID)   return 0;
    if (id == mreg[c][2]) return 1;
    return 2;
  endfunction

  function automatic logic [15:0] exp_rd(int c, logic v, logic w, logic [15:0] id, logic [3:0] idx);
    if (!v || w) return 16'h0;
    if (idx == 0) return SELF_ID;
    if (RD_M[idx-1]) return mreg[c][idx];
    return 16'h0;
  endfunction

  function automatic logic wr_accept(int c, logic v, logic w, logic [15:0] id, logic [3:0] idx);
    int k;
    if (!v || !w || idx == 0) return 1'b0;
    k = mcls(c, id);
    if (k == 0) return swm[c][idx-1];
    if (k == 1) return OWN_WM[idx-1];
    return 1'b0;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 16; k++) mreg[c][k] = 16'h0;
      mreg[c][0] = SELF_ID;
      mreg[c][1] = {8'h00, TYPE_V[7:0]};
      pv[c] = 1'b0; pidx[c] = '0; pdat[c] = '0;
    end
  endtask

  task automatic step(string tag, logic v, logic w, logic [15:0] id, logic [3:0] idx,
                      logic [15:0] wd, logic hv, logic [15:0] hid, logic bl, logic [7:0] bi);
    string t;
    @(negedge clk);
    // R7 / R8: strobe from the previous step
    check("R7 upd_valid A", {15'h0, uv_a}, {15'h0, pv[0]});
    check("R7 upd_valid B", {15'h0, uv_b}, {15'h0, pv[1]});
    if (pv[0]) begin
      check("R7 upd_idx A", {12'h0, ui_a}, {12'h0, pidx[0]});
      check("R7 upd_data A", ud_a, pdat[0]);
    end
    if (pv[1]) begin
      check("R7 upd_idx B", {12'h0, ui_b}, {12'h0, pidx[1]});
      check("R7 upd_data B", ud_b, pdat[1]);
    end
    acc_valid = v; acc_write = w; acc_req_id = id; acc_idx = idx; acc_wdata = wd;
    halt_valid = hv; halt_id = hid; bank_load = bl; bank_idx = bi;
    #1;
    t = (tag != "") ? tag : ((idx == 0) ? "R1" : "R4");
    // R5: same-cycle read data
    check({t, " rd A"}, rd_a, exp_rd(0, v, w, id, idx));
    check({t, " rd B"}, rd_b, exp_rd(1, v, w, id, idx));
    for (int c = 0; c < 2; c++) begin
      logic acc;
      int   k;
      acc = wr_accept(c, v, w, id, idx);
      k   = mcls(c, id);
      pv[c] = acc && (k == 1);
      if (pv[c]) begin pidx[c] = idx; pdat[c] = wd; end
      if (hv && hid == mreg[c][2]) mreg[c][2] = 16'h0;
      if (acc) begin
        if (idx == 1) mreg[c][1][15:8] = wd[15:8];
        else          mreg[c][idx] = wd;
      end
      if (bl) mreg[c][1][15:8] = bi;
    end
  endtask

  task automatic rd(string tag, logic [15:0] id, logic [3:0] idx);
    step(tag, 1'b1, 1'b0, id, idx, 16'h0, 1'b0, 16'h0, 1'b0, 8'h0);
  endtask

  task automatic wr(logic [15:0] id, logic [3:0] idx, logic [15:0] wd);
    step("", 1'b1, 1'b1, id, idx, wd, 1'b0, 16'h0, 1'b0, 8'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    swm[0] = 16'h000C;
    swm[1] = 16'h000E;
    acc_valid = 0; acc_write = 0; acc_req_id = 0; acc_idx = 0; acc_wdata = 0;
    halt_valid = 0; halt_id = 0; bank_load = 0; bank_idx = 0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10 upd_valid", {15'h0, uv_a}, 16'h0);
    check("R10 dev_id", id_a, SELF_ID);
    check("R2 dev_type", {8'h0, ty_b}, {8'h0, TYPE_V[7:0]});
    rd("R10 owner cleared", SELF_ID, 4'd2);
    rd("R10 reg3 cleared", SELF_ID, 4'd3);
    rd("R5 idle", SELF_ID, 4'd1);
    step("R5 no request", 1'b0, 1'b0, SELF_ID, 4'd1, 16'h0, 1'b0, 16'h0, 1'b0, 8'h0);
    // R1: index 0 from an outsider, then a write attempt on it
    rd("R1 ext id", EXT_ID, 4'd0);
    wr(SELF_ID, 4'd0, 16'hFFFF);
    rd("R1 id kept", SELF_ID, 4'd0);
    // R2: type byte and bank load
    rd("R2 type", EXT_ID, 4'd1);
    step("R2 load", 1'b0, 1'b0, 16'h0, 4'd0, 16'h0, 1'b0, 16'h0, 1'b1, 8'h5A);
    rd("R2 bank", EXT_ID, 4'd1);
    // R6: self writes to 3 and 4 stick, to 5 are dropped
    wr(SELF_ID, 4'd3, 16'h1111);
    wr(SELF_ID, 4'd4, 16'h2222);
    wr(SELF_ID, 4'd5, 16'h3333);
    rd("R6 reg3", SELF_ID, 4'd3);
    rd("R6 reg4", SELF_ID, 4'd4);
    rd("R6 reg5 dropped", SELF_ID, 4'd5);
    // R4: index 6 is never readable
    rd("R4 reg6", EXT_ID, 4'd6);
    // R8: outsider write leaves register 4 as it was
    wr(EXT_ID, 4'd4, 16'hDEAD);
    rd("R8 reg4 kept", EXT_ID, 4'd4);
    // R3 / R10: ID 0 is the owner after reset, owner write strobes (R7)
    wr(16'h0000, 4'd5, 16'hBEEF);
    rd("R7 reg5", 16'h0000, 4'd5);
    // R12: grant ownership in the second instance
    wr(SELF_ID, 4'd2, 16'h0077);
    rd("R12 owner set", SELF_ID, 4'd2);
    wr(16'h0077, 4'd5, 16'h4444);
    rd("R3 owner classes", 16'h0077, 4'd5);
    // R11: write to register 2 beats a matching halt
    step("R11 clash", 1'b1, 1'b1, SELF_ID, 4'd2, 16'h0088, 1'b1, 16'h0077, 1'b0, 8'h0);
    rd("R11 write won", SELF_ID, 4'd2);
    // R9: non-matching halt ignored, matching halt clears
    step("R9 miss", 1'b0, 1'b0, 16'h0, 4'd0, 16'h0, 1'b1, 16'h0099, 1'b0, 8'h0);
    rd("R9 kept", SELF_ID, 4'd2);
    step("R9 hit", 1'b0, 1'b0, 16'h0, 4'd0, 16'h0, 1'b1, 16'h0088, 1'b0, 8'h0);
    rd("R9 cleared", SELF_ID, 4'd2);
    // random mix over requesters and indices
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] id, hid;
      int sel;
      sel = $urandom % 4;
      case (sel)
        0: id = SELF_ID;
        1: id = mreg[1][2];
        2: id = 16'h0000;
        default: id = 16'($urandom % 512);
      endcase
      hid = ($urandom % 2 == 0) ? mreg[1][2] : 16'($urandom % 512);
      step("", ($urandom % 8) != 0, ($urandom % 2) == 1, id, 4'($urandom % 16),
           16'($urandom), ($urandom % 8) == 0, hid, ($urandom % 16) == 0, 8'($urandom));
    end
    step("", 1'b0, 1'b0, 16'h0, 4'd0, 16'h0, 1'b0, 16'h0, 1'b0, 8'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule